// File: doc/BRIEF.md
# Breakpoint and Trace Capture Controller

This controller sits next to a CPU bus monitor and decides two things on every bus cycle: whether the cycle is written into trace memory, and whether execution must stop at the end of the current instruction. It takes per-cycle bus information from the monitor: the address, a read qualifier, a strobe that marks the end of a memory or I/O request, a strobe for the clock edge that opens the final T-state, and a strobe for instruction completion. It also takes two programmed address comparators, two external break inputs (one already clock-aligned, one asynchronous), a trace hold input and a window-mode enable.

External break is sampled only on the edge that opens the last T-state. A detected break tags the trace entry with a marker bit and arms a halt. The halt is applied when the instruction completes. Trace hold suppresses trace writes while execution goes on. In window mode only the stretch from an A-comparator hit to a B-comparator hit is traced. Each comparator drives a pulse output, which can trigger a scope or start and stop a signature analyser. While execution is paused, software sets those two outputs to static levels.

Top module: `brk_trace_ctrl`

## Requirements
- R1: After reset, halt_req, paused, trace_we, trace_mark, cmp_a_pulse and cmp_b_pulse are all 0.
- R2: If xbrk_sync_n (combined with the synchronised async input) is 0 in a cycle where last_t is 1 and the block is not paused, a halt is armed. On the first later-or-same cycle with instr_done high, paused goes to 1 and halt_req is high for exactly one cycle, both on the clock edge that samples instr_done.
- R3: A low external break in a cycle where last_t is 0 arms nothing.
- R4: An armed halt does not set paused before the instruction completes. Cycles without instr_done leave paused at 0.
- R5: External break halts even with cmp_halt_en at 0. While paused it has no effect, and it is not remembered after resume.
- R6: xbrk_async_n passes through a two-stage synchroniser. A low level must be present two clock edges before the last_t edge to be seen. A low that starts in the last_t cycle itself is missed.
- R7: trace_mark is 1 on the trace write made in the cycle a break is detected. If no write happens in that cycle, it is 1 on the next trace write. Only that one write is marked, and resume discards a pending mark.
- R8: A request end with trace_hold_n at 0 produces no trace write, and execution state is unaffected.
- R9: trace_we is high one cycle after each bus_req_end, provided the block is not paused, the hold is not active and the window allows it. No trace write occurs while paused.
- R10: A read (bus_rd=1) ending at a comparator's address with that comparator enabled gives a one-cycle high pulse on its output one cycle later. Writes and disabled comparators give none.
- R11: While paused, cmp_a_pulse and cmp_b_pulse equal sw_a_level and sw_b_level.
- R12: With window_en at 1, tracing starts with the cycle that hits comparator A, includes the cycle that hits comparator B, and stops after it. Other cycles outside that range are not traced.
- R13: A resume strobe clears paused and any armed halt on the next edge.
- R14: With cmp_halt_en at 1, a comparator hit arms a halt that is applied at instruction completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | AW | Address of the current bus cycle |
| bus_rd | input | 1 | Current bus cycle is a read |
| bus_req_end | input | 1 | Memory/IO request ends this cycle (trace point) |
| last_t | input | 1 | This edge opens the final T-state of the instruction |
| instr_done | input | 1 | Instruction completes this cycle |
| cmp_a_addr | input | AW | Comparator A address |
| cmp_a_en | input | 1 | Comparator A enable |
| cmp_b_addr | input | AW | Comparator B address |
| cmp_b_en | input | 1 | Comparator B enable |
| cmp_halt_en | input | 1 | Comparator hits arm a halt |
| xbrk_sync_n | input | 1 | Clock-aligned external break, active low |
| xbrk_async_n | input | 1 | Asynchronous external break, active low |
| trace_hold_n | input | 1 | Trace hold, active low |
| window_en | input | 1 | Trace only between A and B hits |
| sw_a_level | input | 1 | Software level for output A while paused |
| sw_b_level | input | 1 | Software level for output B while paused |
| resume | input | 1 | Leave the paused state |
| halt_req | output | 1 | One-cycle halt request |
| paused | output | 1 | Execution is paused |
| trace_we | output | 1 | Trace memory write enable |
| trace_mark | output | 1 | Marker bit for the written entry |
| cmp_a_pulse | output | 1 | Comparator A output |
| cmp_b_pulse | output | 1 | Comparator B output |

## Verification
Break detection, trace writing and instruction completion can all occur in the same cycle. In that case the entry written that cycle must carry the marker, and the halt must be applied at once rather than one instruction later. The bench drives last_t, bus_req_end and instr_done together with a low break and expects trace_we, trace_mark, halt_req and paused all high on the next edge. A second case separates detection from the write and checks that the marker moves to the next write and to that write only.

// File: rtl/brk_pkg.sv
package brk_pkg;
   localparam int unsigned NUM_CMP = 2;
   localparam int unsigned CMP_A   = 0;
   localparam int unsigned CMP_B   = 1;

   typedef struct packed {
      logic detect;
      logic pend;
   } brk_mark_t;
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_n,
   output logic q_n
);
   logic [STAGES-1:0] chain;

   generate
      genvar i;
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d_n;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_n = chain[STAGES-1];
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          rd,
   input  logic          req_end,
   input  logic [AW-1:0] ref_addr,
   input  logic          en,
   input  logic          paused,
   output logic          hit,
   output logic          pulse_q
);
   assign hit = en & rd & req_end & (addr == ref_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= hit & ~paused;
   end
endmodule

// File: rtl/brk_halt.sv
module brk_halt
   import brk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      xbrk_n,
   input  logic      last_t,
   input  logic      cmp_any,
   input  logic      cmp_halt_en,
   input  logic      instr_done,
   input  logic      resume,
   input  logic      write_now,
   output logic      paused,
   output logic      halt_req,
   output brk_mark_t mark
);
   logic armed;
   logic pend;
   logic detect_now;
   logic arm_now;

   assign detect_now = ~paused & ~xbrk_n & last_t;
   assign arm_now    = detect_now | (~paused & cmp_halt_en & cmp_any);
   assign mark.detect = detect_now;
   assign mark.pend   = pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         paused   <= 1'b0;
         halt_req <= 1'b0;
         pend     <= 1'b0;
      end else begin
         halt_req <= 1'b0;
         if (resume) begin
            paused <= 1'b0;
            armed  <= 1'b0;
            pend   <= 1'b0;
         end else begin
            if (!paused && instr_done && (armed || arm_now)) begin
               paused   <= 1'b1;
               halt_req <= 1'b1;
               armed    <= 1'b0;
            end else if (arm_now) begin
               armed <= 1'b1;
            end
            if (write_now)       pend <= 1'b0;
            else if (detect_now) pend <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/brk_trace.sv
module brk_trace
   import brk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_end,
   input  logic      hold_n,
   input  logic      window_en,
   input  logic      hit_a,
   input  logic      hit_b,
   input  logic      paused,
   input  brk_mark_t mark,
   output logic      write_now,
   output logic      trace_we,
   output logic      trace_mark
);
   logic win_open;
   logic win_ok;

   assign win_ok    = ~window_en | win_open | hit_a;
   assign write_now = req_end & ~paused & hold_n & win_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_open   <= 1'b0;
         trace_we   <= 1'b0;
         trace_mark <= 1'b0;
      end else begin
         if (!window_en)  win_open <= 1'b0;
         else if (hit_b)  win_open <= 1'b0;
         else if (hit_a)  win_open <= 1'b1;
         trace_we   <= write_now;
         trace_mark <= write_now & (mark.detect | mark.pend);
      end
   end
endmodule

// File: rtl/brk_trace_ctrl.sv
module brk_trace_ctrl
   import brk_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_rd,
   input  logic          bus_req_end,
   input  logic          last_t,
   input  logic          instr_done,
   input  logic [AW-1:0] cmp_a_addr,
   input  logic          cmp_a_en,
   input  logic [AW-1:0] cmp_b_addr,
   input  logic          cmp_b_en,
   input  logic          cmp_halt_en,
   input  logic          xbrk_sync_n,
   input  logic          xbrk_async_n,
   input  logic          trace_hold_n,
   input  logic          window_en,
   input  logic          sw_a_level,
   input  logic          sw_b_level,
   input  logic          resume,
   output logic          halt_req,
   output logic          paused,
   output logic          trace_we,
   output logic          trace_mark,
   output logic          cmp_a_pulse,
   output logic          cmp_b_pulse
);
   if (AW < 1) begin : g_bad_aw
      $error("brk_trace_ctrl: AW must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("brk_trace_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_CMP-1:0][AW-1:0] ref_addr;
   logic [NUM_CMP-1:0]         ref_en;
   logic [NUM_CMP-1:0]         sw_lvl;
   logic [NUM_CMP-1:0]         hit;
   logic [NUM_CMP-1:0]         pulse_q;
   logic [NUM_CMP-1:0]         pulse_out;
   logic                       async_n_s;
   logic                       xbrk_n;
   logic                       write_now;
   brk_mark_t                  mark;

   assign ref_addr[CMP_A] = cmp_a_addr;
   assign ref_addr[CMP_B] = cmp_b_addr;
   assign ref_en[CMP_A]   = cmp_a_en;
   assign ref_en[CMP_B]   = cmp_b_en;
   assign sw_lvl[CMP_A]   = sw_a_level;
   assign sw_lvl[CMP_B]   = sw_b_level;

   generate
      genvar c;
      for (c = 0; c < NUM_CMP; c++) begin : g_cmp
         brk_cmp #(.AW(AW)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr     (bus_addr),
            .rd       (bus_rd),
            .req_end  (bus_req_end),
            .ref_addr (ref_addr[c]),
            .en       (ref_en[c]),
            .paused   (paused),
            .hit      (hit[c]),
            .pulse_q  (pulse_q[c])
         );
         assign pulse_out[c] = paused ? sw_lvl[c] : pulse_q[c];
      end
   endgenerate

   brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_n   (xbrk_async_n),
      .q_n   (async_n_s)
   );

   assign xbrk_n = xbrk_sync_n & async_n_s;

   brk_halt u_halt (
      .clk         (clk),
      .rst_n       (rst_n),
      .xbrk_n      (xbrk_n),
      .last_t      (last_t),
      .cmp_any     (|hit),
      .cmp_halt_en (cmp_halt_en),
      .instr_done  (instr_done),
      .resume      (resume),
      .write_now   (write_now),
      .paused      (paused),
      .halt_req    (halt_req),
      .mark        (mark)
   );

   brk_trace u_trace (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_end    (bus_req_end),
      .hold_n     (trace_hold_n),
      .window_en  (window_en),
      .hit_a      (hit[CMP_A]),
      .hit_b      (hit[CMP_B]),
      .paused     (paused),
      .mark       (mark),
      .write_now  (write_now),
      .trace_we   (trace_we),
      .trace_mark (trace_mark)
   );

   assign cmp_a_pulse = pulse_out[CMP_A];
   assign cmp_b_pulse = pulse_out[CMP_B];
endmodule

// File: rtl/brk_trace_ctrl_chk.sv
module brk_trace_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_rd,
   input logic bus_req_end,
   input logic instr_done,
   input logic trace_hold_n,
   input logic resume,
   input logic halt_req,
   input logic paused,
   input logic trace_we,
   input logic trace_mark,
   input logic cmp_a_pulse,
   input logic cmp_b_pulse
);
   p_halt_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |=> !halt_req);
   p_halt_with_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> paused);
   p_pause_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused) |-> $past(instr_done));
   p_pause_leave_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(paused) |-> $past(resume));
   p_no_write_paused_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trace_we |-> ($past(bus_req_end) && !$past(paused)));
   p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_req_end) && !$past(trace_hold_n)) |-> !trace_we);
   p_mark_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trace_mark |-> trace_we);
   p_pulse_a_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_a_pulse && !paused) |-> $past(bus_rd && bus_req_end));
   p_pulse_b_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_b_pulse && !paused) |-> $past(bus_rd && bus_req_end));
endmodule

bind brk_trace_ctrl brk_trace_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_rd       (bus_rd),
   .bus_req_end  (bus_req_end),
   .instr_done   (instr_done),
   .trace_hold_n (trace_hold_n),
   .resume       (resume),
   .halt_req     (halt_req),
   .paused       (paused),
   .trace_we     (trace_we),
   .trace_mark   (trace_mark),
   .cmp_a_pulse  (cmp_a_pulse),
   .cmp_b_pulse  (cmp_b_pulse)
);

// File: tb/sim_brk_trace_ctrl.sv
`timescale 1ns/1ps
module sim_brk_trace_ctrl;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_rd = 1'b0, bus_req_end = 1'b0, last_t = 1'b0, instr_done = 1'b0;
   logic [AW-1:0] cmp_a_addr = 16'h1234, cmp_b_addr = 16'h5678;
   logic          cmp_a_en = 1'b1, cmp_b_en = 1'b1, cmp_halt_en = 1'b0;
   logic          xbrk_sync_n = 1'b1, xbrk_async_n = 1'b1, trace_hold_n = 1'b1;
   logic          window_en = 1'b0, sw_a_level = 1'b0, sw_b_level = 1'b0, resume = 1'b0;
   logic          halt_req, paused, trace_we, trace_mark, cmp_a_pulse, cmp_b_pulse;

   brk_trace_ctrl #(.AW(AW), .SYNC_STAGES(2)) u0 (.*);

   always #5 clk = ~clk;

   typedef struct {
      int       cyc;
      logic [5:0] val;
      string    tag;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: outputs as {halt_req, paused, trace_we, trace_mark, cmp_a_pulse, cmp_b_pulse}
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
         exp_t e;
         logic [5:0] act;
         e = exp_q.pop_front();
         act = {halt_req, paused, trace_we, trace_mark, cmp_a_pulse, cmp_b_pulse};
         checks++;
         if (act !== e.val) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%b expected=%b", e.tag, cyc, act, e.val);
         end
      end
   end

   task automatic expect_next(input logic [5:0] v, input string tag);
      exp_t e;
      e.cyc = cyc + 1;
      e.val = v;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
      bus_req_end = 1'b0;
      last_t      = 1'b0;
      instr_done  = 1'b0;
      resume      = 1'b0;
   endtask

   task automatic bus(input logic [AW-1:0] a, input logic rd);
      bus_addr    = a;
      bus_rd      = rd;
      bus_req_end = 1'b1;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      expect_next(6'b000000, "R1 reset state");
      tick();

      // comparator pulses and trace writes
      bus(16'h1234, 1'b1); expect_next(6'b001010, "R9 R10 read hit A"); tick();
      expect_next(6'b000000, "R10 pulse one cycle"); tick();
      bus(16'h1234, 1'b0); expect_next(6'b001000, "R10 write no pulse"); tick();
      trace_hold_n = 1'b0;
      bus(16'h0100, 1'b1); expect_next(6'b000000, "R8 hold blocks write"); tick();
      trace_hold_n = 1'b1;

      // break outside last T-state
      xbrk_sync_n = 1'b0; expect_next(6'b000000, "R3 break no last_t"); tick();
      xbrk_sync_n = 1'b1; instr_done = 1'b1;
      expect_next(6'b000000, "R3 no halt"); tick();

      // armed break, deferred halt
      xbrk_sync_n = 1'b0; last_t = 1'b1; expect_next(6'b000000, "R2 arm"); tick();
      xbrk_sync_n = 1'b1; expect_next(6'b000000, "R4 still running"); tick();
      instr_done = 1'b1; expect_next(6'b110000, "R2 R5 halt at done"); tick();
      expect_next(6'b010000, "R2 halt pulse ends"); tick();

      // paused behaviour
      sw_a_level = 1'b1; expect_next(6'b010010, "R11 sw level A"); tick();
      sw_a_level = 1'b0; sw_b_level = 1'b1;
      bus(16'h1234, 1'b1); expect_next(6'b010001, "R9 R11 no write paused"); tick();
      sw_b_level = 1'b0;
      xbrk_sync_n = 1'b0; last_t = 1'b1; expect_next(6'b010000, "R5 break while paused"); tick();
      xbrk_sync_n = 1'b1; resume = 1'b1; expect_next(6'b000000, "R13 resume"); tick();
      instr_done = 1'b1; expect_next(6'b000000, "R5 R13 no stale halt"); tick();
      bus(16'h0200, 1'b1); expect_next(6'b001000, "R7 pending mark dropped"); tick();

      // detection, write and completion in one cycle
      xbrk_sync_n = 1'b0; last_t = 1'b1; instr_done = 1'b1; bus(16'h0300, 1'b1);
      expect_next(6'b111100, "R7 R2 same cycle"); tick();
      xbrk_sync_n = 1'b1; resume = 1'b1; expect_next(6'b000000, "R13 resume 2"); tick();

      // mark carried to the next write
      xbrk_sync_n = 1'b0; last_t = 1'b1; expect_next(6'b000000, "R7 detect no write"); tick();
      xbrk_sync_n = 1'b1; bus(16'h0300, 1'b1); expect_next(6'b001100, "R7 mark next write"); tick();
      bus(16'h0302, 1'b1); expect_next(6'b001000, "R7 mark once"); tick();
      instr_done = 1'b1; expect_next(6'b110000, "R2 deferred halt"); tick();
      resume = 1'b1; expect_next(6'b000000, "R13 resume 3"); tick();

      // async break too late
      xbrk_async_n = 1'b0; last_t = 1'b1; expect_next(6'b000000, "R6 late async"); tick();
      xbrk_async_n = 1'b1; expect_next(6'b000000, "R6 flush"); tick();
      expect_next(6'b000000, "R6 flush"); tick();
      instr_done = 1'b1; expect_next(6'b000000, "R6 late async ignored"); tick();

      // async break in time
      xbrk_async_n = 1'b0; expect_next(6'b000000, "R6 sync 1"); tick();
      expect_next(6'b000000, "R6 sync 2"); tick();
      last_t = 1'b1; expect_next(6'b000000, "R6 arm"); tick();
      xbrk_async_n = 1'b1; instr_done = 1'b1; expect_next(6'b110000, "R6 async halt"); tick();
      resume = 1'b1; expect_next(6'b000000, "R13 resume 4"); tick();

      // comparator breakpoint halt
      cmp_halt_en = 1'b1;
      bus(16'h5678, 1'b1); expect_next(6'b001001, "R14 hit B arms"); tick();
      instr_done = 1'b1; expect_next(6'b110000, "R14 comparator halt"); tick();
      resume = 1'b1; expect_next(6'b000000, "R13 resume 5"); tick();
      cmp_halt_en = 1'b0;

      // window mode
      window_en = 1'b1;
      bus(16'h0010, 1'b1); expect_next(6'b000000, "R12 before A"); tick();
      bus(16'h1234, 1'b1); expect_next(6'b001010, "R12 A opens"); tick();
      bus(16'h0020, 1'b1); expect_next(6'b001000, "R12 inside"); tick();
      bus(16'h5678, 1'b1); expect_next(6'b001001, "R12 B included"); tick();
      bus(16'h0030, 1'b1); expect_next(6'b000000, "R12 after B"); tick();
      window_en = 1'b0;
      bus(16'h0030, 1'b1); expect_next(6'b001000, "R12 window off"); tick();

      tick();
      tick();
      done = 1'b1;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule